// File: doc/BRIEF.md
# Qualified Event Counter

This block is one programmable activity counter. Each cycle it receives several groups of event lanes, where each lane carries a small count of how many times its source fired in that cycle. An eight-bit select code picks one group. A lane mask picks which lanes in that group are added together. The per-cycle sum then passes through a set of qualifiers before it reaches a 48-bit accumulator:

- a threshold compare, which can be inverted;
- a rising-edge detector;
- a privilege-level filter;
- a global run bit.

Software programs the block through a small register port. Address 0 holds the configuration, address 1 holds the counter value, and address 2 holds the sticky overflow flag. The overflow flag drives an interrupt output while the interrupt enable is set.

The configuration word is laid out as follows:

| Bits | Field |
|------|-------|
| 7:0 | select code |
| 15:8 | lane mask |
| 16 | user-level enable |
| 17 | kernel-level enable |
| 18 | edge mode |
| 19 | invert |
| 20 | interrupt enable |
| 21 | run |
| 23:22 | reserved, read as 0 |
| 31:24 | threshold |

Lane `i` of group `g` sits at event-input bits `[(g*8+i)*3 +: 3]`.

The edge detector is a two-state machine. It starts in `ST_LOW`. It takes transition `T_RISE` to `ST_HIGH` in any cycle where the qualified condition is true. It takes transition `T_FALL` back to `ST_LOW` in any cycle where the condition is false. A count in edge mode is produced only on `T_RISE`.

Top module: `qual_event_counter`

## Requirements
- R1: With threshold 0 and edge mode off, a running counter adds the full per-cycle sum of the selected lanes. For example, lanes 0..7 = 1,2,3,4,5,6,7,0 with mask 0xFF add 28, and all lanes at 7 add 56.
- R2: Mask bit i enables lane i, and set bits combine. Mask 0x18 adds lanes 3 and 4, mask 0x01 adds lane 0 only, and mask 0x00 adds nothing.
- R3: Select code g in the range 0..3 picks group g. A code of 4 or more selects no lanes, so the counter does not advance.
- R4: With a nonzero threshold, the counter adds exactly 1 in a cycle whose sum is greater than or equal to the threshold, and 0 otherwise.
- R5: With invert set and a nonzero threshold, the counter adds 1 when the sum is below the threshold. With threshold 0, invert has no effect.
- R6: In edge mode, the counter adds 1 only on a false-to-true change of the qualified condition. A condition that is already true when run is set is counted once.
- R7: Kernel-level enable counts at privilege 0, and user-level enable counts at privileges 1 to 3. With both enables clear, all levels count.
- R8: With run clear, the counter holds its value.
- R9: A write to address 1 loads the counter on the next clock and discards any increment in that cycle. Read address 1 returns the counter value.
- R10: A carry out of bit 47 sets a sticky flag, read at bit 0 of address 2. The irq output equals flag AND interrupt enable. A write to address 2 loads the flag from data bit 0. A new carry wins over a clearing write in the same cycle.
- R11: After reset, the counter, the flag, the configuration and irq are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 2 | Write address: 0 config, 1 counter, 2 flag |
| reg_wr_data | input | 48 | Write data |
| reg_rd_addr | input | 2 | Read address |
| reg_rd_data | output | 48 | Combinational read data |
| ev_lanes | input | 96 | Four groups of eight 3-bit lane counts |
| cur_priv | input | 2 | Current privilege level |
| irq | output | 1 | Overflow interrupt |

## Verification
The hardest situation to reach from the ports is a counter wrap that falls in the same cycle as a clearing write to the flag. It takes 2^48 increments to get there naturally. The stimulus instead preloads the counter to within one step of all-ones through the register port. It then holds the event lanes active while the flag write is issued, so the carry and the clearing write land on the same clock edge. The edge-at-enable case is reached in a similar way: the lanes are held true under a stopped configuration, and run is then set.

// File: rtl/qec_pkg.sv
package qec_pkg;
    localparam int LANES  = 8;
    localparam int LANE_W = 3;
    localparam int SEL_W  = 8;
    localparam int TH_W   = 8;

    typedef struct packed {
        logic [TH_W-1:0]  thresh;
        logic [1:0]       spare;
        logic             run;
        logic             irq_en;
        logic             inv;
        logic             edge_mode;
        logic             os;
        logic             usr;
        logic [LANES-1:0] umask;
        logic [SEL_W-1:0] evsel;
    } cfg_t;

    typedef enum logic [1:0] {
        RA_CFG    = 2'd0,
        RA_COUNT  = 2'd1,
        RA_STATUS = 2'd2,
        RA_NONE   = 2'd3
    } reg_addr_t;

    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } edge_st_t;
endpackage

// File: rtl/qec_lane_sum.sv
module qec_lane_sum #(
    parameter int NUM_GROUPS = 4,
    parameter int LANES      = 8,
    parameter int LANE_W     = 3,
    parameter int SEL_W      = 8,
    parameter int SUM_W      = 6
) (
    input  logic [NUM_GROUPS*LANES*LANE_W-1:0] ev_lanes,
    input  logic [SEL_W-1:0]                   evsel,
    input  logic [LANES-1:0]                   umask,
    output logic [SUM_W-1:0]                   sum
);
    localparam int GRP_W = LANES * LANE_W;

    logic [GRP_W-1:0]  grp [NUM_GROUPS];
    logic [GRP_W-1:0]  picked;
    logic [LANE_W-1:0] masked [LANES];

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        assign grp[g] = ev_lanes[g*GRP_W +: GRP_W];
    end

    always_comb begin
        picked = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (SEL_W'(g) == evsel) picked = grp[g];
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign masked[i] = umask[i] ? picked[i*LANE_W +: LANE_W] : '0;
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < LANES; i++) begin
            sum = sum + SUM_W'(masked[i]);
        end
    end
endmodule

// File: rtl/qec_qualifier.sv
module qec_qualifier
    import qec_pkg::*;
#(
    parameter int SUM_W = 6,
    parameter int TH_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUM_W-1:0] sum,
    input  logic [TH_W-1:0]  thresh,
    input  logic             inv,
    input  logic             edge_mode,
    input  logic             os,
    input  logic             usr,
    input  logic             run,
    input  logic [1:0]       priv,
    output logic [SUM_W-1:0] inc
);
    localparam int CW = (SUM_W > TH_W) ? SUM_W : TH_W;

    edge_st_t st_q, st_nxt;
    logic     priv_ok, raw_cond, qual, rise, ge;

    always_comb begin
        ge       = CW'(sum) >= CW'(thresh);
        priv_ok  = (!os && !usr) || (os && priv == 2'd0) || (usr && priv != 2'd0);
        raw_cond = (thresh == '0) ? (sum != '0) : (inv ? !ge : ge);
        qual     = run && priv_ok && raw_cond;
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_LOW;
        else        st_q <= st_nxt;
    end

    // Next-state logic and the rise pulse.
    always_comb begin
        st_nxt = st_q;
        rise   = 1'b0;
        unique case (st_q)
            ST_LOW: begin
                if (qual) begin
                    st_nxt = ST_HIGH;   // T_RISE
                    rise   = 1'b1;
                end
            end
            ST_HIGH: begin
                if (!qual) st_nxt = ST_LOW;   // T_FALL
            end
        endcase
    end

    // Increment selection.
    always_comb begin
        if (!qual)                inc = '0;
        else if (edge_mode)       inc = rise ? SUM_W'(1) : '0;
        else if (thresh == '0)    inc = sum;
        else                      inc = SUM_W'(1);
    end
endmodule

// File: rtl/qec_count_core.sv
module qec_count_core #(
    parameter int CNT_W = 48,
    parameter int SUM_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SUM_W-1:0] inc,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             sts_wr,
    input  logic             sts_wbit,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf_q
);
    logic [CNT_W:0] add_full;

    assign add_full = {1'b0, cnt_q} + (CNT_W+1)'(inc);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            cnt_q <= cnt_wr ? cnt_wdata : add_full[CNT_W-1:0];
            if (!cnt_wr && add_full[CNT_W]) ovf_q <= 1'b1;
            else if (sts_wr)                ovf_q <= sts_wbit;
        end
    end
endmodule

// File: rtl/qual_event_counter.sv
module qual_event_counter
    import qec_pkg::*;
#(
    parameter int NUM_GROUPS = 4,
    parameter int CNT_W      = 48
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  reg_wr_en,
    input  logic [1:0]                            reg_wr_addr,
    input  logic [CNT_W-1:0]                      reg_wr_data,
    input  logic [1:0]                            reg_rd_addr,
    output logic [CNT_W-1:0]                      reg_rd_data,
    input  logic [NUM_GROUPS*LANES*LANE_W-1:0]    ev_lanes,
    input  logic [1:0]                            cur_priv,
    output logic                                  irq
);
    localparam int CFG_W = $bits(cfg_t);
    localparam int SUM_W = $clog2(LANES * ((1 << LANE_W) - 1) + 1);

    cfg_t             cfg_q;
    logic             cnt_wr, sts_wr, cfg_wr;
    logic [SUM_W-1:0] sum, inc;
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;

    assign cfg_wr = reg_wr_en && (reg_wr_addr == RA_CFG);
    assign cnt_wr = reg_wr_en && (reg_wr_addr == RA_COUNT);
    assign sts_wr = reg_wr_en && (reg_wr_addr == RA_STATUS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_wr) begin
            cfg_q       <= cfg_t'(reg_wr_data[CFG_W-1:0]);
            cfg_q.spare <= '0;
        end
    end

    qec_lane_sum #(
        .NUM_GROUPS(NUM_GROUPS), .LANES(LANES), .LANE_W(LANE_W),
        .SEL_W(SEL_W), .SUM_W(SUM_W)
    ) u_sum (
        .ev_lanes(ev_lanes), .evsel(cfg_q.evsel), .umask(cfg_q.umask), .sum(sum)
    );

    qec_qualifier #(.SUM_W(SUM_W), .TH_W(TH_W)) u_qual (
        .clk(clk), .rst_n(rst_n), .sum(sum), .thresh(cfg_q.thresh),
        .inv(cfg_q.inv), .edge_mode(cfg_q.edge_mode), .os(cfg_q.os),
        .usr(cfg_q.usr), .run(cfg_q.run), .priv(cur_priv), .inc(inc)
    );

    qec_count_core #(.CNT_W(CNT_W), .SUM_W(SUM_W)) u_core (
        .clk(clk), .rst_n(rst_n), .inc(inc), .cnt_wr(cnt_wr),
        .cnt_wdata(reg_wr_data), .sts_wr(sts_wr), .sts_wbit(reg_wr_data[0]),
        .cnt_q(cnt_q), .ovf_q(ovf_q)
    );

    assign irq = ovf_q && cfg_q.irq_en;

    always_comb begin
        case (reg_rd_addr)
            RA_CFG:    reg_rd_data = CNT_W'(cfg_q);
            RA_COUNT:  reg_rd_data = cnt_q;
            RA_STATUS: reg_rd_data = CNT_W'(ovf_q);
            default:   reg_rd_data = '0;
        endcase
    end
endmodule

// File: rtl/qec_checker.sv
module qec_checker #(
    parameter int CNT_W = 48
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             os,
    input logic             usr,
    input logic             edge_mode,
    input logic [7:0]       thresh,
    input logic [1:0]       priv,
    input logic             cnt_wr,
    input logic             sts_wr,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] cnt_q,
    input logic             ovf_q,
    input logic             irq
);
    p_hold_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt_q));

    p_write_loads_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt_q == $past(wr_data)));

    p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (thresh != 8'd0 && !cnt_wr) |=> ((cnt_q - $past(cnt_q)) <= CNT_W'(1)));

    p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && !cnt_wr) |=> ((cnt_q - $past(cnt_q)) <= CNT_W'(1)));

    p_priv_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (os && !usr && priv != 2'd0 && !cnt_wr) |=> $stable(cnt_q));

    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !sts_wr) |=> ovf_q);

    p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ovf_q);
endmodule

bind qual_event_counter qec_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(cfg_q.run), .os(cfg_q.os), .usr(cfg_q.usr),
    .edge_mode(cfg_q.edge_mode), .thresh(cfg_q.thresh), .priv(cur_priv),
    .cnt_wr(cnt_wr), .sts_wr(sts_wr), .wr_data(reg_wr_data),
    .cnt_q(cnt_q), .ovf_q(ovf_q), .irq(irq)
);

// File: tb/test_qual_event_counter.sv
`timescale 1ns/1ps
module test_qual_event_counter;
    localparam int CNT_W = 48;
    localparam logic [23:0] LA = 24'h1F58D1;   // lanes 0..7 = 1,2,3,4,5,6,7,0
    localparam logic [CNT_W-1:0] ONES = '1;

    typedef struct packed {
        logic [7:0]  umask;
        logic [7:0]  th;
        logic        inv;
        logic        usr;
        logic        os;
        logic [1:0]  priv;
        logic [23:0] lanes;
        logic [7:0]  exp;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{8'hFF, 8'd0,  1'b0, 1'b0, 1'b0, 2'd0, LA,         8'd28}, // R1
        '{8'hFF, 8'd0,  1'b0, 1'b0, 1'b0, 2'd0, 24'hFFFFFF, 8'd56}, // R1 max
        '{8'h18, 8'd0,  1'b0, 1'b0, 1'b0, 2'd0, LA,         8'd9},  // R2
        '{8'h01, 8'd0,  1'b0, 1'b0, 1'b0, 2'd0, LA,         8'd1},  // R2
        '{8'h00, 8'd0,  1'b0, 1'b0, 1'b0, 2'd0, LA,         8'd0},  // R2
        '{8'hFF, 8'd28, 1'b0, 1'b0, 1'b0, 2'd0, LA,         8'd1},  // R4 equal
        '{8'hFF, 8'd29, 1'b0, 1'b0, 1'b0, 2'd0, LA,         8'd0},  // R4 below
        '{8'hFF, 8'd29, 1'b1, 1'b0, 1'b0, 2'd0, LA,         8'd1},  // R5
        '{8'hFF, 8'd28, 1'b1, 1'b0, 1'b0, 2'd0, LA,         8'd0},  // R5
        '{8'hFF, 8'd0,  1'b1, 1'b0, 1'b0, 2'd0, LA,         8'd28}, // R5 inv ignored
        '{8'hFF, 8'd0,  1'b0, 1'b0, 1'b1, 2'd0, LA,         8'd28}, // R7 os ring0
        '{8'hFF, 8'd0,  1'b0, 1'b0, 1'b1, 2'd2, LA,         8'd0},  // R7 os ring2
        '{8'hFF, 8'd0,  1'b0, 1'b1, 1'b0, 2'd3, LA,         8'd28}, // R7 usr ring3
        '{8'hFF, 8'd0,  1'b0, 1'b1, 1'b0, 2'd0, LA,         8'd0},  // R7 usr ring0
        '{8'hFF, 8'd0,  1'b0, 1'b0, 1'b0, 2'd2, LA,         8'd28}, // R7 default
        '{8'hFF, 8'd0,  1'b0, 1'b1, 1'b1, 2'd1, LA,         8'd28}  // R7 both
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr_en = 1'b0;
    logic [1:0]       reg_wr_addr = '0;
    logic [CNT_W-1:0] reg_wr_data = '0;
    logic [1:0]       reg_rd_addr = '0;
    logic [CNT_W-1:0] reg_rd_data;
    logic [95:0]      ev_lanes = '0;
    logic [1:0]       cur_priv = '0;
    logic             irq;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    qual_event_counter i_qual_event_counter (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .ev_lanes(ev_lanes), .cur_priv(cur_priv), .irq(irq)
    );

    function automatic logic [CNT_W-1:0] mk_cfg(input logic [7:0] evsel, umask, th,
            input logic usr, os, edg, inv, ie, run);
        return CNT_W'({th, 2'b00, run, ie, inv, edg, os, usr, umask, evsel});
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
        reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
        tick();
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [CNT_W-1:0] d);
        reg_rd_addr = a;
        #1;
        d = reg_rd_data;
    endtask

    task automatic check(input string tag, input logic [CNT_W-1:0] act, exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic one_cycle(input logic [CNT_W-1:0] cfg, input logic [95:0] ev,
            input logic [1:0] p, output logic [CNT_W-1:0] res);
        ev_lanes = '0;
        wr(2'd0, cfg);
        wr(2'd1, '0);
        ev_lanes = ev; cur_priv = p;
        tick();
        ev_lanes = '0;
        rd(2'd1, res);
    endtask

    initial begin
        #500000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [CNT_W-1:0] v;
        repeat (3) @(negedge clk);
        // R11 reset state
        rd(2'd0, v); check("R11 cfg", v, '0);
        rd(2'd1, v); check("R11 count", v, '0);
        rd(2'd2, v); check("R11 flag", v, '0);
        check("R11 irq", CNT_W'(irq), '0);
        rst_n = 1'b1;
        tick();

        // Table: R1 R2 R4 R5 R7
        for (int k = 0; k < NV; k++) begin
            one_cycle(mk_cfg(8'd0, TBL[k].umask, TBL[k].th, TBL[k].usr, TBL[k].os,
                             1'b0, TBL[k].inv, 1'b0, 1'b1),
                      {72'd0, TBL[k].lanes}, TBL[k].priv, v);
            check($sformatf("table row %0d (R1 R2 R4 R5 R7)", k), v, CNT_W'(TBL[k].exp));
        end
        cur_priv = 2'd0;

        // R3 select code
        one_cycle(mk_cfg(8'd2, 8'hFF, 8'd0, 0, 0, 0, 0, 0, 1), {24'd0, LA, 48'd0}, 2'd0, v);
        check("R3 group2", v, 48'd28);
        one_cycle(mk_cfg(8'd0, 8'hFF, 8'd0, 0, 0, 0, 0, 0, 1), {24'd0, LA, 48'd0}, 2'd0, v);
        check("R3 group0 idle", v, 48'd0);
        one_cycle(mk_cfg(8'd9, 8'hFF, 8'd0, 0, 0, 0, 0, 0, 1), {4{LA}}, 2'd0, v);
        check("R3 out of range", v, 48'd0);

        // R6 edge counting
        ev_lanes = '0;
        wr(2'd0, mk_cfg(8'd0, 8'h01, 8'd1, 0, 0, 1, 0, 0, 1));
        wr(2'd1, '0);
        ev_lanes = 96'h1;
        repeat (4) tick();
        rd(2'd1, v); check("R6 held high", v, 48'd1);
        ev_lanes = '0;
        repeat (2) tick();
        ev_lanes = 96'h1;
        repeat (3) tick();
        rd(2'd1, v); check("R6 second rise", v, 48'd2);
        // R6 condition true before run
        wr(2'd0, mk_cfg(8'd0, 8'h01, 8'd1, 0, 0, 1, 0, 0, 0));
        repeat (3) tick();
        wr(2'd1, '0);
        wr(2'd0, mk_cfg(8'd0, 8'h01, 8'd1, 0, 0, 1, 0, 0, 1));
        repeat (3) tick();
        rd(2'd1, v); check("R6 true at run", v, 48'd1);
        ev_lanes = '0;

        // R8 run clear
        wr(2'd0, mk_cfg(8'd0, 8'hFF, 8'd0, 0, 0, 0, 0, 0, 0));
        wr(2'd1, 48'd7);
        ev_lanes = {72'd0, LA};
        repeat (5) tick();
        rd(2'd1, v); check("R8 stopped", v, 48'd7);

        // R9 write overrides increment
        wr(2'd0, mk_cfg(8'd0, 8'hFF, 8'd0, 0, 0, 0, 0, 0, 1));
        wr(2'd1, 48'd100);
        rd(2'd1, v); check("R9 write wins", v, 48'd100);
        tick();
        rd(2'd1, v); check("R9 resumes", v, 48'd128);
        ev_lanes = '0;

        // R10 overflow
        wr(2'd0, mk_cfg(8'd0, 8'h10, 8'd0, 0, 0, 0, 0, 1, 1));
        wr(2'd1, ONES - 48'd5);
        ev_lanes = {72'd0, LA}; tick(); ev_lanes = '0;
        rd(2'd1, v); check("R10 reach ones", v, ONES);
        rd(2'd2, v); check("R10 no flag yet", v, '0);
        check("R10 irq low", CNT_W'(irq), '0);
        ev_lanes = {72'd0, LA}; tick(); ev_lanes = '0;
        rd(2'd1, v); check("R10 wrapped", v, 48'd4);
        rd(2'd2, v); check("R10 flag set", v, 48'd1);
        check("R10 irq high", CNT_W'(irq), 48'd1);
        wr(2'd0, mk_cfg(8'd0, 8'h10, 8'd0, 0, 0, 0, 0, 0, 1));
        check("R10 irq masked", CNT_W'(irq), '0);
        rd(2'd2, v); check("R10 flag sticky", v, 48'd1);
        wr(2'd2, '0);
        rd(2'd2, v); check("R10 flag cleared", v, '0);
        wr(2'd0, mk_cfg(8'd0, 8'h10, 8'd0, 0, 0, 0, 0, 1, 1));
        wr(2'd1, ONES);
        ev_lanes = {72'd0, LA};
        wr(2'd2, '0);
        ev_lanes = '0;
        rd(2'd2, v); check("R10 wrap beats clear", v, 48'd1);
        rd(2'd1, v); check("R10 wrap value", v, 48'd4);
        check("R10 irq again", CNT_W'(irq), 48'd1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule